// File: doc/BRIEF.md
# UART Status Flag Unit

This block keeps the status and interrupt flags of a low-power UART. It takes single-cycle event strobes from the transmit and receive datapaths. These strobes report that the transmit data register was moved into the shift register, that a start bit was detected, that a reception ended, that a character arrived (with its byte), and that the stop bit of a break character went out. The block also watches the raw clear-to-send (CTS) pin.

From the register interface it takes three writes: a break-request write, a write-one-to-clear write with per-flag clear bits, and a transmit-data write. Enable and match settings arrive as steady levels from the control registers. The block drives a 32-bit status word with fixed bit positions and one interrupt request. The interrupt request is the OR of every flag that has its enable set.

Every flag lives in a sticky set/clear cell. When a set event and a clear arrive in the same cycle, the set wins, so no event is lost. The CTS pin passes through a synchronizer before it is inverted for the status word and before its changes are detected.

Top module: `uart_flag_unit`

## Requirements
- R1: After reset, status bit 7 (transmit-empty) reads 1, every other status bit reads 0, and `irq` is 0 unless `txe_ie` is 1.
- R2: Status bit 18 (break pending) is 1 from the cycle after a `wr_brk_req` pulse. It returns to 0 the cycle after an `ev_brk_stop` pulse. When both pulses arrive in the same cycle, the bit ends at 1.
- R3: Status bit 17 (character match) becomes 1 the cycle after an `ev_char_rcvd` pulse whose `char_data` equals `match_addr`. A received byte that differs from `match_addr` leaves the bit unchanged.
- R4: Status bit 17 is cleared only by a `wr_clr` pulse with `clr_match` = 1. A `wr_clr` pulse with `clr_match` = 0 leaves it at 1, and a match arriving in the same cycle as the clear keeps it at 1.
- R5: Status bit 16 (receive busy) becomes 1 the cycle after `ev_start_bit` and becomes 0 the cycle after `ev_rx_end`. When both arrive in the same cycle, the bit ends at 1.
- R6: Status bit 10 equals the inverse of `cts_pin` as sampled SYNC_STAGES clock edges earlier, so 1 means the line is low. The synchronizer resets to the idle-high line level.
- R7: Status bit 9 (CTS change) sets one cycle after the synchronized CTS level changes, but only while `cts_en` = 1. A `wr_clr` pulse with `clr_cts` = 1 clears it, and a change in the same cycle as the clear wins.
- R8: Status bit 7 sets the cycle after `ev_tdr_moved` and clears the cycle after `wr_tdr`. When both arrive in the same cycle, the bit ends at 1.
- R9: Status bits 31:19, 15:11, 8 and 6:0 always read 0.
- R10: `irq` = (bit17 AND `match_ie`) OR (bit9 AND `cts_ie`) OR (bit7 AND `txe_ie`), combinationally from the current flags and enables.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ev_tdr_moved | input | 1 | Transmit data register moved into shift register |
| ev_start_bit | input | 1 | Valid start bit detected on the receive line |
| ev_rx_end | input | 1 | Reception finished, successfully or not |
| ev_char_rcvd | input | 1 | Character received, byte on `char_data` |
| char_data | input | DATA_W | Received byte |
| ev_brk_stop | input | 1 | Stop bit of a break character being sent |
| cts_pin | input | 1 | Raw asynchronous CTS pin |
| wr_brk_req | input | 1 | Register write requesting a break |
| wr_tdr | input | 1 | Write to the transmit data register |
| wr_clr | input | 1 | Write to the flag-clear register |
| clr_match | input | 1 | Clear bit for the match flag, used with `wr_clr` |
| clr_cts | input | 1 | Clear bit for the CTS change flag, used with `wr_clr` |
| match_addr | input | DATA_W | Byte compared with received characters |
| match_ie | input | 1 | Match interrupt enable |
| cts_en | input | 1 | Enables CTS change detection |
| cts_ie | input | 1 | CTS change interrupt enable |
| txe_ie | input | 1 | Transmit-empty interrupt enable |
| status | output | 32 | Status word |
| irq | output | 1 | Combined interrupt request |

## Verification
The bench builds the block with DATA_W = 8 and SYNC_STAGES = 2. With these values, bytes across the full 8-bit range can be compared against `match_addr`. The CTS path's delay is short enough that a pin toggle can be followed to both status bit 10 and bit 9 within a few cycles. The reference model takes the synchronizer depth from the same bench localparam, so the latency it predicts follows the value the instance is built with. Set/clear collisions are driven on purpose for every flag and are then mixed in a long pseudo-random stretch of strobes and pin toggles.

// File: rtl/uart_flag_pkg.sv
package uart_flag_pkg;

  localparam int STAT_W    = 32;
  localparam int POS_BRK   = 18;
  localparam int POS_MATCH = 17;
  localparam int POS_BUSY  = 16;
  localparam int POS_CTS   = 10;
  localparam int POS_CTSCH = 9;
  localparam int POS_TXE   = 7;

  typedef struct packed {
    logic brk;
    logic match;
    logic busy;
    logic cts;
    logic ctsch;
    logic txe;
  } flags_t;

  function automatic logic [STAT_W-1:0] pack_status(input flags_t f);
    logic [STAT_W-1:0] w;
    w            = '0;
    w[POS_BRK]   = f.brk;
    w[POS_MATCH] = f.match;
    w[POS_BUSY]  = f.busy;
    w[POS_CTS]   = f.cts;
    w[POS_CTSCH] = f.ctsch;
    w[POS_TXE]   = f.txe;
    return w;
  endfunction

  function automatic logic combine_irq(input flags_t f, input logic m_ie,
                                       input logic c_ie, input logic t_ie);
    return (f.match & m_ie) | (f.ctsch & c_ie) | (f.txe & t_ie);
  endfunction

endpackage

// File: rtl/flag_sync.sv
module flag_sync #(
  parameter int STAGES  = 2,
  parameter bit RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_i,
  output logic q_o
);
  localparam int LAST = STAGES - 1;

  logic [LAST:0] chain;

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain[0] <= RST_VAL;
          else        chain[0] <= d_i;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain[s] <= RST_VAL;
          else        chain[s] <= chain[s-1];
        end
      end
    end
  endgenerate

  assign q_o = chain[LAST];
endmodule

// File: rtl/sticky_flag.sv
module sticky_flag #(
  parameter bit RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic q_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     q_o <= RST_VAL;
    else if (set_i) q_o <= 1'b1;
    else if (clr_i) q_o <= 1'b0;
  end
endmodule

// File: rtl/char_matcher.sv
module char_matcher #(
  parameter int DATA_W = 8
) (
  input  logic              strobe_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic [DATA_W-1:0] ref_i,
  output logic              hit_o
);
  assign hit_o = strobe_i && (data_i == ref_i);
endmodule

// File: rtl/uart_flag_unit.sv
module uart_flag_unit
  import uart_flag_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ev_tdr_moved,
  input  logic              ev_start_bit,
  input  logic              ev_rx_end,
  input  logic              ev_char_rcvd,
  input  logic [DATA_W-1:0] char_data,
  input  logic              ev_brk_stop,
  input  logic              cts_pin,
  input  logic              wr_brk_req,
  input  logic              wr_tdr,
  input  logic              wr_clr,
  input  logic              clr_match,
  input  logic              clr_cts,
  input  logic [DATA_W-1:0] match_addr,
  input  logic              match_ie,
  input  logic              cts_en,
  input  logic              cts_ie,
  input  logic              txe_ie,
  output logic [31:0]       status,
  output logic              irq
);
  // named internal events, visible to the bound checker
  logic   match_hit;
  logic   cts_sync;
  logic   cts_prev;
  logic   cts_edge;
  logic   cts_set;
  logic   match_clr;
  logic   ctsch_clr;
  flags_t flags;

  char_matcher #(.DATA_W(DATA_W)) u_match (
    .strobe_i (ev_char_rcvd),
    .data_i   (char_data),
    .ref_i    (match_addr),
    .hit_o    (match_hit)
  );

  flag_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_cts_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_i   (cts_pin),
    .q_o   (cts_sync)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cts_prev <= 1'b1;
    else        cts_prev <= cts_sync;
  end

  assign cts_edge  = cts_sync ^ cts_prev;
  assign cts_set   = cts_edge & cts_en;
  assign match_clr = wr_clr & clr_match;
  assign ctsch_clr = wr_clr & clr_cts;

  sticky_flag #(.RST_VAL(1'b0)) u_brk (
    .clk(clk), .rst_n(rst_n), .set_i(wr_brk_req), .clr_i(ev_brk_stop), .q_o(flags.brk));

  sticky_flag #(.RST_VAL(1'b0)) u_mat (
    .clk(clk), .rst_n(rst_n), .set_i(match_hit), .clr_i(match_clr), .q_o(flags.match));

  sticky_flag #(.RST_VAL(1'b0)) u_busy (
    .clk(clk), .rst_n(rst_n), .set_i(ev_start_bit), .clr_i(ev_rx_end), .q_o(flags.busy));

  sticky_flag #(.RST_VAL(1'b0)) u_ctsch (
    .clk(clk), .rst_n(rst_n), .set_i(cts_set), .clr_i(ctsch_clr), .q_o(flags.ctsch));

  sticky_flag #(.RST_VAL(1'b1)) u_txe (
    .clk(clk), .rst_n(rst_n), .set_i(ev_tdr_moved), .clr_i(wr_tdr), .q_o(flags.txe));

  assign flags.cts = ~cts_sync;

  assign status = pack_status(flags);
  assign irq    = combine_irq(flags, match_ie, cts_ie, txe_ie);
endmodule

// File: rtl/uart_flag_checker.sv
module uart_flag_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        wr_brk_req,
  input logic        ev_brk_stop,
  input logic        ev_start_bit,
  input logic        ev_tdr_moved,
  input logic        wr_clr,
  input logic        clr_match,
  input logic        cts_en,
  input logic        match_ie,
  input logic        cts_ie,
  input logic        txe_ie,
  input logic        match_hit,
  input logic        cts_edge,
  input logic [31:0] status,
  input logic        irq
);
  AST_BRK_SET: assert property (@(posedge clk) disable iff (!rst_n)
    wr_brk_req |=> status[18]); // R2
  AST_BRK_SELF_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_brk_stop && !wr_brk_req) |=> !status[18]); // R2
  AST_MATCH_SET: assert property (@(posedge clk) disable iff (!rst_n)
    match_hit |=> status[17]); // R3
  AST_MATCH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (status[17] && !(wr_clr && clr_match)) |=> status[17]); // R4
  AST_BUSY_SET: assert property (@(posedge clk) disable iff (!rst_n)
    ev_start_bit |=> status[16]); // R5
  AST_CTS_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (cts_edge && cts_en) |=> status[9]); // R7
  AST_CTS_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    (!cts_en && !status[9]) |=> !status[9]); // R7
  AST_TXE_SET: assert property (@(posedge clk) disable iff (!rst_n)
    ev_tdr_moved |=> status[7]); // R8
  AST_IRQ_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !(match_ie || cts_ie || txe_ie) |-> !irq); // R10
endmodule

bind uart_flag_unit uart_flag_checker i_uart_flag_checker (
  .clk          (clk),
  .rst_n        (rst_n),
  .wr_brk_req   (wr_brk_req),
  .ev_brk_stop  (ev_brk_stop),
  .ev_start_bit (ev_start_bit),
  .ev_tdr_moved (ev_tdr_moved),
  .wr_clr       (wr_clr),
  .clr_match    (clr_match),
  .cts_en       (cts_en),
  .match_ie     (match_ie),
  .cts_ie       (cts_ie),
  .txe_ie       (txe_ie),
  .match_hit    (match_hit),
  .cts_edge     (cts_edge),
  .status       (status),
  .irq          (irq)
);

// File: tb/test_uart_flag_unit.sv
module test_uart_flag_unit;
  localparam int CLK_PER = 10;
  localparam int SYNC    = 2;

  logic       clk = 0;
  logic       rst_n = 0;
  logic       ev_tdr_moved = 0, ev_start_bit = 0, ev_rx_end = 0, ev_char_rcvd = 0;
  logic [7:0] char_data = 0;
  logic       ev_brk_stop = 0, cts_pin = 1, wr_brk_req = 0, wr_tdr = 0;
  logic       wr_clr = 0, clr_match = 0, clr_cts = 0;
  logic [7:0] match_addr = 8'h5A;
  logic       match_ie = 0, cts_en = 0, cts_ie = 0, txe_ie = 0;
  logic [31:0] status;
  logic        irq;

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 0;

  uart_flag_unit #(.DATA_W(8), .SYNC_STAGES(SYNC)) i_uart_flag_unit (
    .clk(clk), .rst_n(rst_n), .ev_tdr_moved(ev_tdr_moved), .ev_start_bit(ev_start_bit),
    .ev_rx_end(ev_rx_end), .ev_char_rcvd(ev_char_rcvd), .char_data(char_data),
    .ev_brk_stop(ev_brk_stop), .cts_pin(cts_pin), .wr_brk_req(wr_brk_req),
    .wr_tdr(wr_tdr), .wr_clr(wr_clr), .clr_match(clr_match), .clr_cts(clr_cts),
    .match_addr(match_addr), .match_ie(match_ie), .cts_en(cts_en), .cts_ie(cts_ie),
    .txe_ie(txe_ie), .status(status), .irq(irq)
  );

  always #(CLK_PER/2) clk = ~clk;

  // behavioural reference model
  int m_brk, m_mat, m_busy, m_ch, m_txe;
  bit pin_hist[$];

  function automatic int line_level(int age);
    return pin_hist[age];
  endfunction

  task automatic cmp(string tag, int act, int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s at %0t: actual %0d expected %0d", tag, $time, act, exp);
    end
  endtask

  task automatic compare_all();
    int lvl;
    int exp_irq;
    lvl = line_level(SYNC - 1);
    cmp("R2 break bit18", status[18], m_brk);
    cmp("R3 match bit17", status[17], m_mat);
    cmp("R5 busy bit16", status[16], m_busy);
    cmp("R6 cts bit10", status[10], (lvl == 0) ? 1 : 0);
    cmp("R7 cts change bit9", status[9], m_ch);
    cmp("R8 txe bit7", status[7], m_txe);
    cmp("R9 reserved bits", ((status >> 19) != 0 || status[15:11] != 0 || status[8] || status[6:0] != 0) ? 1 : 0, 0);
    exp_irq = ((m_mat != 0 && match_ie) || (m_ch != 0 && cts_ie) || (m_txe != 0 && txe_ie)) ? 1 : 0;
    cmp("R10 irq", irq, exp_irq);
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      m_brk = 0; m_mat = 0; m_busy = 0; m_ch = 0; m_txe = 1;
      pin_hist.delete();
      for (int k = 0; k < SYNC + 1; k++) pin_hist.push_front(1'b1);
    end else begin
      // change seen by the synchronized line before this edge
      bit moved;
      moved = line_level(SYNC - 1) != line_level(SYNC);
      if (wr_brk_req) m_brk = 1; else if (ev_brk_stop) m_brk = 0;
      if (ev_char_rcvd && char_data == match_addr) m_mat = 1;
      else if (wr_clr && clr_match) m_mat = 0;
      if (ev_start_bit) m_busy = 1; else if (ev_rx_end) m_busy = 0;
      if (moved && cts_en) m_ch = 1; else if (wr_clr && clr_cts) m_ch = 0;
      if (ev_tdr_moved) m_txe = 1; else if (wr_tdr) m_txe = 0;
      pin_hist.push_front(cts_pin);
      void'(pin_hist.pop_back());
      #(CLK_PER/4);
      if (!done) compare_all();
    end
  end

  task automatic drop_strobes();
    ev_tdr_moved = 0; ev_start_bit = 0; ev_rx_end = 0; ev_char_rcvd = 0;
    ev_brk_stop = 0; wr_brk_req = 0; wr_tdr = 0; wr_clr = 0; clr_match = 0; clr_cts = 0;
  endtask

  task automatic next(int n = 1);
    repeat (n) @(negedge clk);
    drop_strobes();
  endtask

  initial begin
    #(CLK_PER * 200000);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual running expected finished");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    cmp("R1 reset status", status, 32'h0000_0080);
    cmp("R1 reset irq", irq, 0);
    txe_ie = 1;
    #1 cmp("R1 irq from txe", irq, 1);
    next(2);
    // R8 write clears, move sets, collision
    wr_tdr = 1; next();
    next(2);
    ev_tdr_moved = 1; next();
    wr_tdr = 1; ev_tdr_moved = 1; next();
    next(2);
    // R2 break request and self clear
    wr_brk_req = 1; next(); next(3);
    ev_brk_stop = 1; next(); next();
    wr_brk_req = 1; ev_brk_stop = 1; next(); next();
    ev_brk_stop = 1; next(); next();
    // R3 match, mismatch first
    match_ie = 1;
    char_data = 8'h11; ev_char_rcvd = 1; next(); next();
    char_data = 8'h5A; ev_char_rcvd = 1; next(); next(2);
    // R4 clear without its bit, then with it, then collision
    wr_clr = 1; clr_cts = 1; next(); next();
    wr_clr = 1; clr_match = 1; next(); next();
    wr_clr = 1; clr_match = 1; ev_char_rcvd = 1; next(); next();
    wr_clr = 1; clr_match = 1; next(); next();
    match_addr = 8'hFF; char_data = 8'hFF; ev_char_rcvd = 1; next(); next();
    // R5 busy
    ev_start_bit = 1; next(); next(2);
    ev_rx_end = 1; next(); next();
    ev_start_bit = 1; ev_rx_end = 1; next(); next();
    ev_rx_end = 1; next(); next();
    // R6 R7 cts gated off, then on
    cts_en = 0; cts_pin = 0; next(5);
    cts_pin = 1; next(5);
    cts_en = 1; cts_ie = 1; cts_pin = 0; next(5);
    wr_clr = 1; clr_cts = 1; next(); next(2);
    cts_pin = 1; next(SYNC);
    wr_clr = 1; clr_cts = 1; next(); next(3);
    // pseudo-random mixture
    for (int i = 0; i < 3000; i++) begin
      logic [31:0] r;
      r = $urandom;
      ev_tdr_moved = r[0] & r[1]; wr_tdr = r[2] & r[3];
      ev_start_bit = r[4] & r[5]; ev_rx_end = r[6] & r[7];
      ev_char_rcvd = r[8]; char_data = r[9] ? match_addr : r[17:10];
      ev_brk_stop = r[18] & r[19]; wr_brk_req = r[20] & r[21];
      wr_clr = r[22]; clr_match = r[23]; clr_cts = r[24];
      if (r[25] & r[26]) cts_pin = ~cts_pin;
      if (r[27] & r[28] & r[29]) begin
        match_ie = ~match_ie; cts_en = ~cts_en; cts_ie = r[30]; txe_ie = r[31];
      end
      next();
    end
    next(4);
    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule